// File: doc/BRIEF.md
# Predicate Break-Before Propagation Unit

This unit turns a governing lane mask, a predicate carried from the previous vector partition and a condition predicate into a result predicate that stays true up to the first true condition and stops there. There is one bit per byte lane, and the lane count is a parameter. The break state is seeded from the previous partition. The seed is the previous-partition bit at the highest-numbered active lane. If that bit is false, the whole result is zero. Lanes outside the governing mask give zero and take no part in the break.

Four condition flags are produced with the result, all computed over active lanes only. N is the first active result bit. Z means no active result bit is set. C is the inverse of the last active result bit. V is always clear.

The unit has a start/done pulse interface. A two-state machine controls it:
- `ST_IDLE`: waits. A start pulse latches all three predicates and moves the machine to `ST_EVAL`.
- `ST_EVAL`: registers the result and flags, pulses done for one cycle and always returns to `ST_IDLE`.

Top module: `lane_break_unit`

## Requirements
- R1: A start sampled high in `ST_IDLE` latches mask, prev and cond. The next clock edge raises done for exactly one cycle, and result and flags update on that same edge. After reset, done, the result and all flags are 0.
- R2: Every result bit whose mask bit is 0 is 0.
- R3: If the prev bit at the highest-numbered lane with mask=1 is 0, the result is all zeros.
- R4: If that seed bit is 1, the result is 1 on active lanes below the first active lane with cond=1. That lane and every active lane above it give 0. The outcome equals a serial evaluation that walks from lane 0 upward.
- R5: A cond bit set on a lane with mask=0 does not stop the break chain.
- R6: N equals the result bit at the lowest-numbered active lane.
- R7: Z is 1 exactly when the result has no bit set.
- R8: C is the inverse of the result bit at the highest-numbered active lane.
- R9: V is always 0.
- R10: With an all-zero mask, the result is 0, N=0, Z=1, C=1 and V=0.
- R11: A start that is still high while in `ST_EVAL` is ignored: a start held for two cycles gives one done pulse.
- R12: Result and flags hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted in `ST_IDLE` |
| mask_i | input | LANES | Governing lane mask |
| prev_i | input | LANES | Previous-partition predicate |
| cond_i | input | LANES | Condition predicate |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | LANES | Result predicate |
| flag_n_o | output | 1 | First active result bit |
| flag_z_o | output | 1 | No active result bit set |
| flag_c_o | output | 1 | Inverse of last active result bit |
| flag_v_o | output | 1 | Always zero |

## Verification
Directed cases cover the distinct routes through the chain:
- A false seed separates R3 from R4.
- A cond bit placed only on an inactive lane shows whether the mask gates the break (R5).
- A break at lane 0 and a break at the top lane exercise the extremes of the prefix network.
- Sparse masks, whose highest active lane is not the top lane, test the seed lookup and the N and C flags.
- The empty mask covers the corner case of R10.

Random triples of mask, prev and cond are then compared against a serial lane-by-lane model. Any misrouted prefix stage shows up as a difference from that model.

// File: rtl/lane_break_pkg.sv
package lane_break_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } lbrk_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } lbrk_flags_t;
endpackage

// File: rtl/lbrk_seed.sv
module lbrk_seed #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] mask_i,
    input  logic [LANES-1:0] prev_i,
    output logic             seed_o
);
    // the last active lane wins: scan upward, keep overwriting
    always_comb begin
        seed_o = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (mask_i[i]) seed_o = prev_i[i];
        end
    end
endmodule

// File: rtl/lbrk_chain.sv
module lbrk_chain #(
    parameter int LANES = 32
) (
    input  logic             seed_i,
    input  logic [LANES-1:0] mask_i,
    input  logic [LANES-1:0] cond_i,
    output logic [LANES-1:0] result_o
);
    localparam int LEVELS = $clog2(LANES);

    // inclusive prefix OR of "kill" (active and cond) in log2 stages
    logic [LANES-1:0] pfx [0:LEVELS];

    assign pfx[0] = mask_i & cond_i;

    for (genvar s = 0; s < LEVELS; s++) begin : g_stage
        localparam int DIST = 1 << s;
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            if (i >= DIST) begin : g_or
                assign pfx[s+1][i] = pfx[s][i] | pfx[s][i-DIST];
            end else begin : g_pass
                assign pfx[s+1][i] = pfx[s][i];
            end
        end
    end

    assign result_o = {LANES{seed_i}} & ~pfx[LEVELS] & mask_i;
endmodule

// File: rtl/lbrk_flags.sv
module lbrk_flags
    import lane_break_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] mask_i,
    input  logic [LANES-1:0] result_i,
    output lbrk_flags_t      flags_o
);
    logic first_bit;
    logic last_bit;

    always_comb begin
        first_bit = 1'b0;
        last_bit  = 1'b0;
        // downward scan: the lowest active lane is written last
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask_i[i]) first_bit = result_i[i];
        end
        // upward scan: the highest active lane is written last
        for (int i = 0; i < LANES; i++) begin
            if (mask_i[i]) last_bit = result_i[i];
        end
    end

    assign flags_o.n = first_bit;
    assign flags_o.z = ~|(result_i & mask_i);
    assign flags_o.c = ~last_bit;
    assign flags_o.v = 1'b0;
endmodule

// File: rtl/lane_break_unit.sv
module lane_break_unit
    import lane_break_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LANES-1:0] mask_i,
    input  logic [LANES-1:0] prev_i,
    input  logic [LANES-1:0] cond_i,
    output logic             done_o,
    output logic [LANES-1:0] result_o,
    output logic             flag_n_o,
    output logic             flag_z_o,
    output logic             flag_c_o,
    output logic             flag_v_o
);
    lbrk_state_e      state_q, state_d;
    logic [LANES-1:0] mask_q, prev_q, cond_q;
    logic             seed;
    logic [LANES-1:0] res_comb;
    lbrk_flags_t      flags_comb;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
        endcase
    end

    // operand latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            prev_q <= '0;
            cond_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            mask_q <= mask_i;
            prev_q <= prev_i;
            cond_q <= cond_i;
        end
    end

    lbrk_seed  #(.LANES(LANES)) u_seed  (.mask_i(mask_q), .prev_i(prev_q), .seed_o(seed));
    lbrk_chain #(.LANES(LANES)) u_chain (.seed_i(seed), .mask_i(mask_q), .cond_i(cond_q),
                                         .result_o(res_comb));
    lbrk_flags #(.LANES(LANES)) u_flags (.mask_i(mask_q), .result_i(res_comb), .flags_o(flags_comb));

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            result_o <= '0;
            flag_n_o <= 1'b0;
            flag_z_o <= 1'b0;
            flag_c_o <= 1'b0;
            flag_v_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: ;
                ST_EVAL: begin
                    done_o   <= 1'b1;
                    result_o <= res_comb;
                    flag_n_o <= flags_comb.n;
                    flag_z_o <= flags_comb.z;
                    flag_c_o <= flags_comb.c;
                    flag_v_o <= flags_comb.v;
                end
            endcase
        end
    end

    a_r1_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (state_q == ST_EVAL) ##1 done_o);
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r2_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((result_o & ~mask_q) == '0));
    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flag_z_o == (result_o == '0)));
    a_r9_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_v_o);
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o) || $past(state_q) == ST_EVAL);
endmodule

// File: tb/lane_break_unit_tb_top.sv
module lane_break_unit_tb_top;
    localparam int LANES = 32;

    typedef struct {
        logic [LANES-1:0] res;
        logic n, z, c;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [LANES-1:0] mask_i = '0, prev_i = '0, cond_i = '0;
    logic done_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o;
    logic [LANES-1:0] result_o;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];
    exp_t last_exp;

    always #10 clk = ~clk;

    lane_break_unit #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mask_i(mask_i), .prev_i(prev_i), .cond_i(cond_i),
        .done_o(done_o), .result_o(result_o),
        .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
        .flag_c_o(flag_c_o), .flag_v_o(flag_v_o)
    );

    task automatic chk(input string req, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // serial lane-by-lane model
    function automatic exp_t model(input logic [LANES-1:0] m, input logic [LANES-1:0] p,
                                   input logic [LANES-1:0] c, input string tag);
        exp_t e;
        logic run, fnd;
        run = 1'b0;
        for (int i = 0; i < LANES; i++) if (m[i]) run = p[i];
        e.res = '0;
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) begin
                run = run && !c[i];
                e.res[i] = run;
            end
        end
        fnd = 1'b0; e.n = 1'b0; e.c = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (m[i] && !fnd) begin e.n = e.res[i]; fnd = 1'b1; end
            if (m[i]) e.c = !e.res[i];
        end
        e.z = (e.res == '0);
        e.tag = tag;
        return e;
    endfunction

    task automatic run_op(input logic [LANES-1:0] m, input logic [LANES-1:0] p,
                          input logic [LANES-1:0] c, input string tag, input bit hold2 = 0);
        @(negedge clk);
        mask_i = m; prev_i = p; cond_i = c; start_i = 1'b1;
        sb.push_back(model(m, p, c, tag));
        @(negedge clk);
        if (hold2) @(negedge clk);
        start_i = 1'b0;
        mask_i = ~m; cond_i = ~c;
        if (!hold2) @(negedge clk);
        @(negedge clk);
        chk("R1 done low after pulse", {31'b0, done_o}, '0);
        if (hold2) begin
            @(negedge clk);
            chk("R11 no second done", {31'b0, done_o}, '0);
        end
        repeat (2) @(negedge clk);
        chk("R12 result held", result_o, last_exp.res);
        chk("R12 flags held", {29'b0, flag_n_o, flag_z_o, flag_c_o}, {29'b0, last_exp.n, last_exp.z, last_exp.c});
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R1 unexpected done act=1 exp=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                last_exp = e;
                chk({e.tag, " result"}, result_o, e.res);
                chk("R6 flag N", {31'b0, flag_n_o}, {31'b0, e.n});
                chk("R7 flag Z", {31'b0, flag_z_o}, {31'b0, e.z});
                chk("R8 flag C", {31'b0, flag_c_o}, {31'b0, e.c});
                chk("R9 flag V", {31'b0, flag_v_o}, '0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset done", {31'b0, done_o}, '0);
        chk("R1 reset result", result_o, '0);
        chk("R1 reset flags", {28'b0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, '0);
        rst_n = 1'b1;

        run_op('1, '1, 32'h0000_0100, "R4 break at lane 8");
        run_op('1, 32'h7fff_ffff, 32'h0000_0100, "R3 seed false");
        run_op('1, '1, 32'h0000_0001, "R4 break at lane 0");
        run_op('1, '1, 32'h8000_0000, "R4 break at top lane");
        run_op('1, '1, 32'h0, "R4 no break");
        run_op(32'h00ff_00f0, 32'h0080_0000, 32'h0000_ff00, "R5 cond on inactive lanes");
        run_op(32'h0f0f_0f0f, 32'h0800_0000, 32'h0000_0f00, "R2 sparse mask");
        run_op(32'h0000_00f0, 32'h0000_0080, 32'h0000_0010, "R6 first active breaks");
        run_op(32'h0, '1, '1, "R10 empty mask");
        run_op(32'h0000_0100, 32'h0000_0100, 32'h0, "R8 single lane");
        run_op('1, '1, 32'h0000_0400, "R11 held start", 1'b1);
        for (int k = 0; k < 40; k++) begin
            logic [LANES-1:0] m, c;
            m = $urandom; c = $urandom & $urandom & $urandom;
            run_op(m, $urandom, c, "R4 random");
        end

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 missing done act=%0d exp=0", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog act=hung exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule